// File: doc/BRIEF.md
# Embedded Controller Power Sequencer

This block is the always-on sequencing logic of a notebook embedded controller. It runs on a fast core clock, and a one-cycle `tick` strobe at the 32.768 kHz standby rate times every delay. The block decides when to switch on the chipset standby rails. With an adapter attached it switches them on by itself. On battery alone it waits for the user power switch, so that a parked machine draws as little as possible.

Once the standby regulators report good and stay good for a settling window, the block releases the active-low resume reset to the chipset. A debounced press of the power switch is then sent on to the chipset as a delayed high-low-high pulse on the power-button line. A press that wakes the rails from battery is held pending and sent on once the chipset is out of resume reset. If the regulators never report good, the rails are dropped and a sticky fault blocks any further attempt until reset.

Top module: `ec_power_sequencer`

## Requirements
- R1: While the rails are off and no fault is latched, a high `adapter_in` drives `standby_en` high on the next clock edge, with no switch press needed.
- R2: With `battery_in` high, `adapter_in` low and no switch press, `standby_en` stays low. With both sources low it stays low whatever the switch does.
- R3: On battery alone, a debounced press (falling edge of the filtered `power_sw_n`) drives `standby_en` high.
- R4: `resume_rst_n` goes high only after `standby_good` has been high for RELEASE_TICKS consecutive ticks while the rails are enabled. If `standby_good` drops, `resume_rst_n` goes low on the next edge and the count starts again.
- R5: A press accepted while the rails are on or waking is sent on after BUTTON_DELAY_TICKS ticks, counted once `resume_rst_n` is high. It appears as `pwrbtn_n` held low for exactly BUTTON_LOW_TICKS ticks, beginning at a tick edge. `pwrbtn_n` is never low while `resume_rst_n` is low.
- R6: A press that arrives while a forward is pending, delaying or driving low is ignored and produces no extra pulse.
- R7: If `standby_good` is not seen within GOOD_TIMEOUT_TICKS ticks of enabling the rails, `standby_en` goes low and `fault` goes high. `fault` then holds, and the rails stay off, until `rst_n` is asserted.
- R8: Losing the adapter while the battery is present leaves the rails and `resume_rst_n` as they are. Losing both sources drops `standby_en` and `resume_rst_n` on the next edge and discards any pending press.
- R9: `power_sw_n` passes through a two-flop synchroniser. Its filtered level changes only after DEBOUNCE_SAMPLES consecutive tick samples that differ from it, so a shorter low level has no effect on `pwrbtn_n`.
- R10: While `rst_n` is low: `standby_en` = 0, `resume_rst_n` = 0, `pwrbtn_n` = 1, `fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz standby rate |
| adapter_in | input | 1 | Debounced adapter-present |
| battery_in | input | 1 | Battery-present |
| power_sw_n | input | 1 | Raw user power switch, low when pressed |
| standby_good | input | 1 | Good indication from the standby regulators |
| standby_en | output | 1 | Enable for the chipset standby rails |
| resume_rst_n | output | 1 | Active-low resume reset to the chipset, high once standby power is valid |
| pwrbtn_n | output | 1 | Active-low power-button pulse to the chipset |
| fault | output | 1 | Sticky flag: standby-good timeout |

## Verification
The properties assume that `tick` is a single-cycle strobe. They also assume that `adapter_in`, `battery_in` and `standby_good` are already synchronous to `clk` and change at most once per cycle. The bench honours this by producing `tick` as one clock in four and by changing every input only on the falling clock edge. It never models the regulator itself: `standby_good` is set by hand, so timeouts and dropouts come from explicit stimulus. Only `power_sw_n` is handled as truly asynchronous, and the bench holds it long enough, or deliberately too briefly, relative to the debounce window.

// File: rtl/ecps_pkg.sv
package ecps_pkg;
  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_RAMP   = 2'd1,
    PS_SETTLE = 2'd2,
    PS_ON     = 2'd3
  } pwr_state_t;

  typedef enum logic [1:0] {
    BP_IDLE  = 2'd0,
    BP_DELAY = 2'd1,
    BP_LOW   = 2'd2
  } btn_phase_t;
endpackage

// File: rtl/ecps_tick_counter.sv
module ecps_tick_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign done = tick && !clear && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_n = cnt_q;
    if (clear)     cnt_n = '0;
    else if (done) cnt_n = '0;
    else if (tick) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ecps_switch_filter.sv
module ecps_switch_filter #(
  parameter int SAMPLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_raw_n,
  output logic press
);
  localparam int CW = (SAMPLES < 2) ? 1 : $clog2(SAMPLES);

  logic          meta_q, sync_q;
  logic          level_q, level_n;
  logic [CW-1:0] run_q, run_n;
  logic          press_q, press_n;

  always_comb begin
    level_n = level_q;
    run_n   = run_q;
    if (tick) begin
      if (sync_q == level_q) begin
        run_n = '0;
      end else if (run_q == CW'(SAMPLES - 1)) begin
        level_n = sync_q;
        run_n   = '0;
      end else begin
        run_n = run_q + 1'b1;
      end
    end
    press_n = level_q && !level_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b1;
      sync_q  <= 1'b1;
      level_q <= 1'b1;
      run_q   <= '0;
      press_q <= 1'b0;
    end else begin
      meta_q  <= sw_raw_n;
      sync_q  <= meta_q;
      level_q <= level_n;
      run_q   <= run_n;
      press_q <= press_n;
    end
  end

  assign press = press_q;
endmodule

// File: rtl/ecps_button_pulse.sv
module ecps_button_pulse
  import ecps_pkg::*;
#(
  parameter int DELAY_TICKS = 33,
  parameter int LOW_TICKS   = 655
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic start,
  output logic busy,
  output logic drive_low
);
  btn_phase_t phase_q, phase_n;
  logic       dly_done, low_done;

  ecps_tick_counter #(.LIMIT(DELAY_TICKS)) dly_ctr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clear(phase_q != BP_DELAY), .done(dly_done)
  );

  ecps_tick_counter #(.LIMIT(LOW_TICKS)) low_ctr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clear(phase_q != BP_LOW), .done(low_done)
  );

  always_comb begin
    phase_n = phase_q;
    if (!enable) begin
      phase_n = BP_IDLE;
    end else begin
      case (phase_q)
        BP_IDLE:  if (start)    phase_n = BP_DELAY;
        BP_DELAY: if (dly_done) phase_n = BP_LOW;
        BP_LOW:   if (low_done) phase_n = BP_IDLE;
        default:                phase_n = BP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= BP_IDLE;
    else        phase_q <= phase_n;
  end

  assign busy      = (phase_q != BP_IDLE);
  assign drive_low = (phase_q == BP_LOW);
endmodule

// File: rtl/ec_power_sequencer.sv
module ec_power_sequencer
  import ecps_pkg::*;
#(
  parameter int DEBOUNCE_SAMPLES   = 8,
  parameter int RELEASE_TICKS      = 328,
  parameter int GOOD_TIMEOUT_TICKS = 3277,
  parameter int BUTTON_DELAY_TICKS = 33,
  parameter int BUTTON_LOW_TICKS   = 655
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic adapter_in,
  input  logic battery_in,
  input  logic power_sw_n,
  input  logic standby_good,
  output logic standby_en,
  output logic resume_rst_n,
  output logic pwrbtn_n,
  output logic fault
);
  pwr_state_t state_q, state_n;
  logic       fault_q, fault_n;
  logic       pend_q, pend_n;
  logic       press, to_done, rel_done;
  logic       btn_busy, btn_low, btn_start;
  logic       any_src;

  assign any_src = adapter_in || battery_in;

  ecps_switch_filter #(.SAMPLES(DEBOUNCE_SAMPLES)) sw_filt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sw_raw_n(power_sw_n), .press(press)
  );

  ecps_tick_counter #(.LIMIT(GOOD_TIMEOUT_TICKS)) timeout_ctr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clear(state_q != PS_RAMP), .done(to_done)
  );

  ecps_tick_counter #(.LIMIT(RELEASE_TICKS)) release_ctr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clear((state_q != PS_SETTLE) || !standby_good), .done(rel_done)
  );

  assign btn_start = pend_q && (state_q == PS_ON) && !btn_busy;

  ecps_button_pulse #(
    .DELAY_TICKS(BUTTON_DELAY_TICKS),
    .LOW_TICKS  (BUTTON_LOW_TICKS)
  ) btn_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .enable(state_q == PS_ON), .start(btn_start),
    .busy(btn_busy), .drive_low(btn_low)
  );

  // rail sequencing
  always_comb begin
    state_n = state_q;
    fault_n = fault_q;
    case (state_q)
      PS_OFF: begin
        if (!fault_q && (adapter_in || (battery_in && press))) state_n = PS_RAMP;
      end
      PS_RAMP: begin
        if (!any_src)          state_n = PS_OFF;
        else if (standby_good) state_n = PS_SETTLE;
        else if (to_done) begin
          state_n = PS_OFF;
          fault_n = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (!any_src)      state_n = PS_OFF;
        else if (rel_done) state_n = PS_ON;
      end
      PS_ON: begin
        if (!any_src)           state_n = PS_OFF;
        else if (!standby_good) state_n = PS_SETTLE;
      end
      default: state_n = PS_OFF;
    endcase
  end

  // pending press bookkeeping
  always_comb begin
    pend_n = pend_q;
    if (btn_start) pend_n = 1'b0;
    if (press && !pend_q && !btn_busy && (state_n != PS_OFF)) pend_n = 1'b1;
    if (state_n == PS_OFF) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      fault_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      fault_q <= fault_n;
      pend_q  <= pend_n;
    end
  end

  assign standby_en   = (state_q != PS_OFF);
  assign resume_rst_n = (state_q == PS_ON);
  assign pwrbtn_n     = !(btn_low && (state_q == PS_ON));
  assign fault        = fault_q;
endmodule

// File: rtl/ec_power_sequencer_chk.sv
module ec_power_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic adapter_in,
  input logic battery_in,
  input logic standby_good,
  input logic standby_en,
  input logic resume_rst_n,
  input logic pwrbtn_n,
  input logic fault
);
  a_r1_adapter_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_en && adapter_in && !fault) |=> standby_en);

  a_r4_release_needs_rails: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst_n |-> standby_en);

  a_r4_good_drop_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_rst_n && !standby_good) |=> !resume_rst_n);

  a_r5_pulse_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrbtn_n |-> resume_rst_n);

  a_r5_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrbtn_n) |-> $past(tick));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r7_fault_rails_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !standby_en);

  a_r8_sources_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_en && !adapter_in && !battery_in) |=> !standby_en);
endmodule

bind ec_power_sequencer ec_power_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .adapter_in(adapter_in), .battery_in(battery_in),
  .standby_good(standby_good), .standby_en(standby_en),
  .resume_rst_n(resume_rst_n), .pwrbtn_n(pwrbtn_n), .fault(fault)
);

// File: tb/ec_power_sequencer_tb.sv
module ec_power_sequencer_tb_top;
  localparam int TDIV = 4;
  localparam int DEB  = 8;
  localparam int REL  = 6;
  localparam int TO   = 20;
  localparam int DLY  = 3;
  localparam int LOWT = 30;

  typedef struct packed {
    logic       a;
    logic       b;
    logic       g;
    logic [7:0] w;
    logic       en;
    logic       rs;
    logic       ft;
  } vec_t;

  // adapter, battery, good, ticks to wait, expected en, resume, fault
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0},  // no source: off (R2)
    '{1'b0, 1'b1, 1'b0, 8'd10, 1'b0, 1'b0, 1'b0},  // battery, no press (R2)
    '{1'b1, 1'b1, 1'b0, 8'd2,  1'b1, 1'b0, 1'b0},  // adapter wakes (R1)
    '{1'b1, 1'b1, 1'b1, 8'd2,  1'b1, 1'b0, 1'b0},  // still settling (R4)
    '{1'b1, 1'b1, 1'b1, 8'd6,  1'b1, 1'b1, 1'b0},  // released (R4)
    '{1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0},  // adapter lost (R8)
    '{1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0, 1'b0},  // both lost (R8)
    '{1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0}
  };

  logic clk, rst_n, tick;
  logic adapter_in, battery_in, power_sw_n, standby_good;
  logic standby_en, resume_rst_n, pwrbtn_n, fault;
  logic [1:0] tdiv_q;
  int n_chk, n_err, falls, low_clks;
  bit finished;
  logic pw_prev;

  ec_power_sequencer #(
    .DEBOUNCE_SAMPLES(DEB), .RELEASE_TICKS(REL), .GOOD_TIMEOUT_TICKS(TO),
    .BUTTON_DELAY_TICKS(DLY), .BUTTON_LOW_TICKS(LOWT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .adapter_in(adapter_in), .battery_in(battery_in),
    .power_sw_n(power_sw_n), .standby_good(standby_good),
    .standby_en(standby_en), .resume_rst_n(resume_rst_n),
    .pwrbtn_n(pwrbtn_n), .fault(fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv_q <= (rst_n === 1'b0) ? 2'd0 : tdiv_q + 2'd1;
    tick   <= (tdiv_q == 2'(TDIV - 1));
    pw_prev <= pwrbtn_n;
    if (pw_prev === 1'b1 && pwrbtn_n === 1'b0) falls <= falls + 1;
    if (pwrbtn_n === 1'b0) low_clks <= low_clks + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * TDIV) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 10);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int f0, l0;
    n_chk = 0; n_err = 0; falls = 0; low_clks = 0; finished = 0;
    tdiv_q = '0; tick = 1'b0; pw_prev = 1'b1;
    rst_n = 1'b0; adapter_in = 1'b0; battery_in = 1'b0;
    power_sw_n = 1'b1; standby_good = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset values
    chk("R10 en", standby_en, 0);
    chk("R10 resume", resume_rst_n, 0);
    chk("R10 pwrbtn", pwrbtn_n, 1);
    chk("R10 fault", fault, 0);
    rst_n = 1'b1;
    ticks(1);

    for (int i = 0; i < 8; i++) begin
      adapter_in = VEC[i].a;
      battery_in = VEC[i].b;
      standby_good = VEC[i].g;
      ticks(int'(VEC[i].w));
      chk($sformatf("R1 R2 R4 R8 vector %0d en", i), standby_en, VEC[i].en);
      chk($sformatf("R4 R8 vector %0d resume", i), resume_rst_n, VEC[i].rs);
      chk($sformatf("R7 vector %0d fault", i), fault, VEC[i].ft);
    end

    // R3 battery press wakes rails, R5 pending press forwarded
    battery_in = 1'b1;
    f0 = falls; l0 = low_clks;
    power_sw_n = 1'b0;
    ticks(12);
    chk("R3 battery press wakes", standby_en, 1);
    chk("R5 no pulse before release", pwrbtn_n, 1);
    standby_good = 1'b1;
    power_sw_n = 1'b1;
    ticks(REL + 2);
    chk("R4 release after settle", resume_rst_n, 1);
    ticks(40);
    chk("R5 one pulse forwarded", falls - f0, 1);
    chk("R5 pulse width", low_clks - l0, LOWT * TDIV);

    // R6 second press during pulse ignored
    f0 = falls;
    power_sw_n = 1'b0; ticks(10);
    power_sw_n = 1'b1; ticks(10);
    power_sw_n = 1'b0; ticks(10);
    power_sw_n = 1'b1; ticks(50);
    chk("R6 second press ignored", falls - f0, 1);

    // R9 short low level filtered out
    f0 = falls;
    power_sw_n = 1'b0; ticks(5);
    power_sw_n = 1'b1; ticks(DLY + 20);
    chk("R9 glitch no pulse", falls - f0, 0);
    chk("R9 glitch pwrbtn high", pwrbtn_n, 1);

    // R4 good dropout
    standby_good = 1'b0; ticks(1);
    chk("R4 dropout reasserts", resume_rst_n, 0);
    chk("R4 dropout rails kept", standby_en, 1);
    standby_good = 1'b1; ticks(2);
    chk("R4 restart count", resume_rst_n, 0);
    ticks(REL);
    chk("R4 re-release", resume_rst_n, 1);

    // R7 timeout fault
    battery_in = 1'b0; standby_good = 1'b0; ticks(2);
    chk("R8 off again", standby_en, 0);
    adapter_in = 1'b1; ticks(TO + 3);
    chk("R7 timeout rails off", standby_en, 0);
    chk("R7 fault set", fault, 1);
    standby_good = 1'b1;
    power_sw_n = 1'b0; ticks(12);
    power_sw_n = 1'b1; ticks(12);
    chk("R7 no restart", standby_en, 0);
    chk("R7 fault holds", fault, 1);

    // R10 reset clears fault, R1 wake afterwards
    rst_n = 1'b0; ticks(1);
    chk("R10 fault cleared", fault, 0);
    chk("R10 rails off", standby_en, 0);
    chk("R10 pwrbtn idle", pwrbtn_n, 1);
    rst_n = 1'b1; ticks(1);
    chk("R1 wake after reset", standby_en, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule